// File: doc/BRIEF.md
# Subcarrier Load-Modulation Encoder

This block turns a serial stream of response bits into the on/off drive pattern that a proximity card's load switch uses to answer a reader. It runs on the carrier clock and divides it by eight, which gives a transmit sample rate of twice the 847.5 kHz subcarrier. The subcarrier therefore changes level on every sample. Each data bit lasts sixteen samples, which is 128 carrier cycles. The point in the carrier cycle where each sample starts is set by a phase input.

One control byte selects the coding and the drive strength. When its low nibble is 1, the subcarrier runs through the whole bit and its phase follows the bit value (BPSK). When the low nibble is 2, the subcarrier is present in only one half of the bit (Manchester). Any other low-nibble value switches the encoder off. The high nibble is passed to the two-bit depth output. Bits enter through a valid/ready handshake, and ready is offered only at a bit boundary.

The controller has three states. OFF is entered from any state whenever the coding code is not valid; OFF goes to IDLE once the code is valid. IDLE goes to SEND on the first sample tick with a bit offered (transition "accept"). SEND stays in SEND at the last sample of a bit if another bit is offered ("chain"), and goes back to IDLE if none is ("drain").

Top module: `sc_mod_encoder`

## Requirements
- R1: A sample tick occurs once every 8 carrier cycles, and samples advance only on a tick. Counting posedges since reset release, the tick occurs in the cycle where the count modulo 8 equals `tx_phase`.
- R2: `bit_ready` is high for exactly one carrier cycle at each bit boundary: on every tick in IDLE, and on the tick that ends sample 15 in SEND. While bits are chained, successive ready pulses are 128 cycles apart. A bit is taken when `bit_valid` and `bit_ready` are both high at a posedge; sample 0 of that bit starts at that edge.
- R3: With `tx_ctrl[3:0]`=2 and data bit 1, `mod_en` equals (sample index is odd) during samples 0–7 and is low during samples 8–15.
- R4: With `tx_ctrl[3:0]`=2 and data bit 0, `mod_en` is low during samples 0–7 and equals (sample index is odd) during samples 8–15.
- R5: With `tx_ctrl[3:0]`=1, `mod_en` during sample s equals (s odd) XOR (data bit). The subcarrier is therefore present throughout the bit, and its phase inverts whenever the bit value changes.
- R6: If no bit is offered at a boundary, the block returns to IDLE and `mod_en` stays low until a bit is accepted.
- R7: If `tx_ctrl[3:0]` is any value other than 1 or 2, `bit_ready` stays low and `mod_en` is low from the next carrier cycle on. This holds even if the change happens in the middle of a bit, which is then dropped.
- R8: `mod_depth` equals `tx_ctrl[7:4]` when that field is 0–3, and equals 3 for larger values. It follows the field in every state, including during reset.
- R9: While `rst_n` is low, `mod_en` and `bit_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_ctrl | input | 8 | Low nibble: coding (1 BPSK, 2 Manchester); high nibble: depth |
| tx_phase | input | 3 | Carrier cycle, modulo 8, at which a sample tick occurs |
| bit_data | input | 1 | Data bit offered |
| bit_valid | input | 1 | Data bit offered is valid |
| bit_ready | output | 1 | Bit taken at this edge if valid |
| mod_en | output | 1 | Load-modulation enable |
| mod_depth | output | 2 | Modulation depth level |

## Verification
`mod_depth` is combinational, so it is checked at the first falling edge after `tx_ctrl` changes. Each accepted bit is timed from its accept edge: sample s is visible on falling edges 8s to 8s+7 after that edge, and the bench samples at 8s. The next ready pulse is expected at falling edge 127, which is seven falling edges after the last sample is checked. The tick phase is checked by comparing the bench's own posedge count since reset, modulo 8, with `tx_phase` when ready appears in IDLE. An abort by an invalid code is expected to show on the very next falling edge.

// File: rtl/sc_enc_pkg.sv
package sc_enc_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_SEND
    } enc_state_t;

    localparam logic [3:0] CODE_BPSK  = 4'd1;
    localparam logic [3:0] CODE_MANCH = 4'd2;
endpackage

// File: rtl/sc_enc_clkgen.sv
module sc_enc_clkgen #(
    parameter int DIV = 8,
    localparam int PW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase,
    output logic          tick
);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == phase);

    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $stable(phase)) |=> !tick);
endmodule

// File: rtl/sc_enc_depth.sv
module sc_enc_depth (
    input  logic [3:0] level_in,
    output logic [1:0] depth
);
    always_comb begin
        if (level_in > 4'd3) depth = 2'd3;
        else                 depth = level_in[1:0];
    end
endmodule

// File: rtl/sc_enc_fsm.sv
module sc_enc_fsm
    import sc_enc_pkg::*;
#(
    parameter int SPB = 16,
    localparam int SW = $clog2(SPB)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [3:0] code,
    input  logic       bit_valid,
    input  logic       bit_data,
    output logic       bit_ready,
    output logic       mod_en
);
    localparam logic [SW-1:0] LAST = SW'(SPB - 1);
    localparam logic [SW-1:0] HALF = SW'(SPB / 2);

    enc_state_t    state, nxt;
    logic [SW-1:0] samp;
    logic          cur;
    logic          code_ok, is_bpsk, boundary, accept, first_half;

    assign code_ok   = (code == CODE_BPSK) || (code == CODE_MANCH);
    assign is_bpsk   = (code == CODE_BPSK);
    assign boundary  = (state == ST_IDLE) || ((state == ST_SEND) && (samp == LAST));
    assign bit_ready = code_ok && tick && boundary;
    assign accept    = bit_ready && bit_valid;

    always_comb begin
        nxt = state;
        if (!code_ok) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_IDLE;
                ST_IDLE: nxt = accept ? ST_SEND : ST_IDLE;
                ST_SEND: begin
                    if (tick && samp == LAST) nxt = accept ? ST_SEND : ST_IDLE;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            samp  <= '0;
            cur   <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                samp <= '0;
                cur  <= bit_data;
            end else if (tick && state == ST_SEND) begin
                samp <= samp + 1'b1;
            end
        end
    end

    assign first_half = (samp < HALF);

    always_comb begin
        mod_en = 1'b0;
        unique case (state)
            ST_SEND: begin
                if (is_bpsk) mod_en = samp[0] ^ cur;
                else         mod_en = samp[0] && (cur ? first_half : !first_half);
            end
            ST_OFF, ST_IDLE: mod_en = 1'b0;
            default:         mod_en = 1'b0;
        endcase
    end

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state == ST_SEND && samp == '0));
    // R1
    samp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !tick) |=> $stable(samp));
    // R7
    off_on_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_ok |=> (state == ST_OFF));
    // R6
    quiet_outside_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SEND) |-> !mod_en);
endmodule

// File: rtl/sc_mod_encoder.sv
module sc_mod_encoder #(
    parameter int DIV = 8,
    parameter int SPB = 16,
    localparam int PW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    tx_ctrl,
    input  logic [PW-1:0] tx_phase,
    input  logic          bit_data,
    input  logic          bit_valid,
    output logic          bit_ready,
    output logic          mod_en,
    output logic [1:0]    mod_depth
);
    logic tick;

    sc_enc_clkgen #(.DIV(DIV)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (tx_phase),
        .tick  (tick)
    );

    sc_enc_fsm #(.SPB(SPB)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .code      (tx_ctrl[3:0]),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .bit_ready (bit_ready),
        .mod_en    (mod_en)
    );

    sc_enc_depth u_depth (
        .level_in (tx_ctrl[7:4]),
        .depth    (mod_depth)
    );
endmodule

// File: tb/test_sc_mod_encoder.sv
module test_sc_mod_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_ctrl = 8'h02;
    logic [2:0] tx_phase = 3'd0;
    logic       bit_data = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_ready, mod_en;
    logic [1:0] mod_depth;
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    sc_mod_encoder i_sc_mod_encoder (
        .clk(clk), .rst_n(rst_n), .tx_ctrl(tx_ctrl), .tx_phase(tx_phase),
        .bit_data(bit_data), .bit_valid(bit_valid), .bit_ready(bit_ready),
        .mod_en(mod_en), .mod_depth(mod_depth)
    );

    // ctrl[23:16] phase[15:12] nbits[11:8] bits[7:0], bit 0 sent first
    localparam logic [23:0] VECS [5] = '{
        24'h02_0_4_0B, 24'h12_3_4_06, 24'h21_5_5_13, 24'h31_7_3_02, 24'hF2_1_2_02
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic wait_ready(output int waits);
        waits = 1;
        @(negedge clk);
        while (!bit_ready) begin
            @(negedge clk);
            waits++;
        end
    endtask

    task automatic send_bit(input logic b, input logic [3:0] code, input bit gap_chk);
        int waits;
        int expv;
        bit_data  = b;
        bit_valid = 1'b1;
        wait_ready(waits);
        if (gap_chk) chk("R2 ready spacing", waits, 7);
        @(negedge clk);
        bit_valid = 1'b0;
        for (int s = 0; s < 16; s++) begin
            if (code == 4'd1) expv = (s % 2) ^ b;
            else if (b)       expv = (s < 8) ? (s % 2) : 0;
            else              expv = (s < 8) ? 0 : (s % 2);
            chk(code == 4'd1 ? "R5 bpsk" : (b ? "R3 manchester one" : "R4 manchester zero"),
                mod_en, expv);
            if (s < 15) repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int waits;
        int hits;
        // R9 reset state, R8 depth during reset
        tx_ctrl = 8'h22;
        repeat (3) @(negedge clk);
        chk("R9 mod_en in reset", mod_en, 0);
        chk("R9 ready in reset", bit_ready, 0);
        chk("R8 depth in reset", mod_depth, 2);
        rst_n = 1'b1;

        foreach (VECS[v]) begin
            logic [7:0] ctrl = VECS[v][23:16];
            logic [3:0] ph   = VECS[v][15:12];
            logic [3:0] nb   = VECS[v][11:8];
            logic [7:0] bits = VECS[v][7:0];
            tx_ctrl  = ctrl;
            tx_phase = ph[2:0];
            repeat (3) @(negedge clk);
            chk("R8 depth", mod_depth, (ctrl[7:4] > 3) ? 3 : ctrl[7:4]);
            wait_ready(waits);
            chk("R1 tick phase", cyc % 8, ph);
            for (int i = 0; i < nb; i++) send_bit(bits[i], ctrl[3:0], i > 0);
            repeat (8) @(negedge clk);
            hits = 0;
            for (int k = 0; k < 24; k++) begin
                @(negedge clk);
                if (mod_en) hits++;
            end
            chk("R6 idle quiet", hits, 0);
        end

        // R7 invalid code: no ready, no modulation
        tx_ctrl = 8'h23;
        bit_valid = 1'b1;
        hits = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (bit_ready || mod_en) hits++;
        end
        chk("R7 invalid code quiet", hits, 0);
        chk("R8 depth with invalid code", mod_depth, 2);
        bit_valid = 1'b0;

        // R7 abort mid-bit
        tx_ctrl = 8'h02;
        tx_phase = 3'd2;
        repeat (2) @(negedge clk);
        bit_data = 1'b1;
        bit_valid = 1'b1;
        wait_ready(waits);
        @(negedge clk);
        bit_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk("R3 before abort", mod_en, 1);
        tx_ctrl = 8'h00;
        @(negedge clk);
        chk("R7 abort mid-bit", mod_en, 0);
        chk("R7 ready off", bit_ready, 0);
        tx_ctrl = 8'h02;
        repeat (20) @(negedge clk);
        chk("R6 after abort no resume", mod_en, 0);

        summary();
    end
endmodule